// File: doc/BRIEF.md
# Bidirectional NAND Emulation Chain with Fault Injection

This block emulates a chain of 2-input NAND gates in clocked logic so that values can move through each gate in either direction. Every net is held in its own register. In forward mode each output register loads the NAND of its two input registers. In backward mode the output registers hold, and each input register is driven from the gate outputs. A driven output of 0 pulls both of that gate's inputs to 1. A driven output of 1 pulls an input to 0 when the other input is 1. Any other case leaves the input unchanged. Only NAND cells are used, so any circuit is built from one cell type.

The cells are chained. Cell k reads net k as its first input and net k+1 as its second input, so every inner net is an input to two cells. That shared net is held in a single register. A multiplexer picks which cell's backward value loads it.

Each gate output has stuck-at-0 and stuck-at-1 fault controls and preset and clear controls. It also has a plain external force. Each input net has a force of its own. A per-cell stable flag shows whether the output register would keep its value on the next edge. This lets a controller apply a pattern at the outputs, let the inputs settle, and inject faults.

Top module: `nand_emu_chain`

## Requirements
- R1: An active-low asynchronous reset clears every net register and every output register to 0 at once.
- R2: With mode_i = 0 (forward) and no output override, output register k loads NOT(net k AND net k+1) on the next edge. In forward mode an input net with no force keeps its value.
- R3: With mode_i = 1 (backward) and no override, an output register keeps its value. A cell whose output is 0 drives both of its input nets to 1.
- R4: In backward mode, a cell whose output is 1 drives an input net to 0 when its other input is 1. It leaves that net alone when its other input is 0.
- R5: A net shared by cell j-1 (as its second input) and cell j (as its first input) takes the value from cell j-1 when that cell determines it. It takes the value from cell j only otherwise. If neither cell determines it, the net holds.
- R6: Stuck-at-0 on a cell forces its output register to 0 on the next edge. This applies in either mode and overrides every other control.
- R7: Stuck-at-1 forces the output register to 1 on the next edge whenever stuck-at-0 is low. It overrides preset, clear, force and the mode logic.
- R8: Preset loads 1 and clear loads 0 into the output register, with preset winning over clear. Both rank below the faults and above the external output force.
- R9: An external force loads its value into an input net or output register on the next edge. It overrides the forward and backward logic, but for outputs it ranks below faults, preset and clear.
- R10: stable_o[k] is 1 exactly when the value about to load output register k equals the value it holds now.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 forward evaluation, 1 backward justification |
| in_force_en_i | input | N_CELLS+1 | Per-net force enable, bit j is net j |
| in_force_val_i | input | N_CELLS+1 | Per-net force value |
| out_force_en_i | input | N_CELLS | Per-cell output force enable |
| out_force_val_i | input | N_CELLS | Per-cell output force value |
| sa0_i | input | N_CELLS | Per-cell stuck-at-0 injection |
| sa1_i | input | N_CELLS | Per-cell stuck-at-1 injection |
| preset_i | input | N_CELLS | Per-cell output preset to 1 |
| clear_i | input | N_CELLS | Per-cell output clear to 0 |
| net_o | output | N_CELLS+1 | Current net register values |
| out_o | output | N_CELLS | Current output register values |
| stable_o | output | N_CELLS | Per-cell output stability flag |

## Verification
Every register is visible at net_o or out_o. A wrong next-state choice therefore shows up one edge after the cycle that caused it. Examples are the wrong override winning, a shared net taking the wrong cell's value, or a hold that moves. A wrong stable_o shows in the same cycle, because the flag is combinational from the held state and the current controls. The bench compares all three port groups every cycle against a reference model. It tags each mismatch with the rule that chose the expected value. The stimulus is a seeded random mix plus directed corner cases, and it covers both modes and all override combinations.

// File: rtl/nand_emu_pkg.sv
package nand_emu_pkg;

  typedef enum logic {
    MODE_FWD = 1'b0,
    MODE_BWD = 1'b1
  } emu_mode_e;

  // Backward request one cell makes on one of its input nets
  typedef struct packed {
    logic det;
    logic val;
  } fb_t;

  // Input is determined unless output is 1 and the other input is 0
  function automatic fb_t justify(logic y, logic other);
    fb_t r;
    r.det = ~y | other;
    r.val = ~y;
    return r;
  endfunction

endpackage

// File: rtl/nand_emu_cell.sv
module nand_emu_cell
  import nand_emu_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  emu_mode_e mode_i,
  input  logic      a_i,
  input  logic      b_i,
  input  logic      force_en_i,
  input  logic      force_val_i,
  input  logic      sa0_i,
  input  logic      sa1_i,
  input  logic      preset_i,
  input  logic      clear_i,
  output logic      y_o,
  output logic      stable_o,
  output fb_t       a_fb_o,
  output fb_t       b_fb_o
);

  logic y_q, y_d;

  // Override ladder: faults, then preset/clear, then force, then mode
  always_comb begin
    if (sa0_i)                 y_d = 1'b0;
    else if (sa1_i)            y_d = 1'b1;
    else if (preset_i)         y_d = 1'b1;
    else if (clear_i)          y_d = 1'b0;
    else if (force_en_i)       y_d = force_val_i;
    else if (mode_i == MODE_FWD) y_d = ~(a_i & b_i);
    else                       y_d = y_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= 1'b0;
    else         y_q <= y_d;
  end

  assign y_o      = y_q;
  assign stable_o = (y_d == y_q);
  assign a_fb_o   = justify(y_q, b_i);
  assign b_fb_o   = justify(y_q, a_i);

  p_sa0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sa0_i |=> !y_o);

  p_sa1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sa0_i && sa1_i) |=> y_o);

  p_preset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sa0_i && !sa1_i && preset_i) |=> y_o);

  p_fwd_nand_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sa0_i && !sa1_i && !preset_i && !clear_i && !force_en_i && mode_i == MODE_FWD)
      |=> (y_o == ~($past(a_i) & $past(b_i))));

  p_bwd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sa0_i && !sa1_i && !preset_i && !clear_i && !force_en_i && mode_i == MODE_BWD)
      |=> $stable(y_o));

  p_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stable_o |=> $stable(y_o));

endmodule

// File: rtl/nand_emu_net.sv
module nand_emu_net
  import nand_emu_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  emu_mode_e mode_i,
  input  logic      force_en_i,
  input  logic      force_val_i,
  input  fb_t       lo_fb_i,
  input  fb_t       hi_fb_i,
  output logic      q_o
);

  logic q_q, q_d;

  // Shared-net mux: lower cell wins when it determines the value
  always_comb begin
    if (force_en_i)                             q_d = force_val_i;
    else if (mode_i == MODE_BWD && lo_fb_i.det) q_d = lo_fb_i.val;
    else if (mode_i == MODE_BWD && hi_fb_i.det) q_d = hi_fb_i.val;
    else                                        q_d = q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  p_force_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_en_i |=> (q_o == $past(force_val_i)));

  p_fwd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_en_i && mode_i == MODE_FWD) |=> $stable(q_o));

  p_lo_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_en_i && mode_i == MODE_BWD && lo_fb_i.det) |=> (q_o == $past(lo_fb_i.val)));

  p_undet_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_en_i && !lo_fb_i.det && !hi_fb_i.det) |=> $stable(q_o));

endmodule

// File: rtl/nand_emu_chain.sv
module nand_emu_chain
  import nand_emu_pkg::*;
#(
  parameter int unsigned N_CELLS = 4,
  localparam int unsigned N_NETS = N_CELLS + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic [N_NETS-1:0]  in_force_en_i,
  input  logic [N_NETS-1:0]  in_force_val_i,
  input  logic [N_CELLS-1:0] out_force_en_i,
  input  logic [N_CELLS-1:0] out_force_val_i,
  input  logic [N_CELLS-1:0] sa0_i,
  input  logic [N_CELLS-1:0] sa1_i,
  input  logic [N_CELLS-1:0] preset_i,
  input  logic [N_CELLS-1:0] clear_i,
  output logic [N_NETS-1:0]  net_o,
  output logic [N_CELLS-1:0] out_o,
  output logic [N_CELLS-1:0] stable_o
);

  emu_mode_e mode;
  assign mode = emu_mode_e'(mode_i);

  logic [N_NETS-1:0] net_q;
  fb_t a_fb [N_CELLS];
  fb_t b_fb [N_CELLS];
  fb_t lo_fb [N_NETS];
  fb_t hi_fb [N_NETS];

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    nand_emu_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_i      (mode),
      .a_i         (net_q[k]),
      .b_i         (net_q[k+1]),
      .force_en_i  (out_force_en_i[k]),
      .force_val_i (out_force_val_i[k]),
      .sa0_i       (sa0_i[k]),
      .sa1_i       (sa1_i[k]),
      .preset_i    (preset_i[k]),
      .clear_i     (clear_i[k]),
      .y_o         (out_o[k]),
      .stable_o    (stable_o[k]),
      .a_fb_o      (a_fb[k]),
      .b_fb_o      (b_fb[k])
    );
  end

  for (genvar j = 0; j < N_NETS; j++) begin : g_net
    // lo side: net j is the second input of cell j-1
    if (j > 0) begin : g_lo
      assign lo_fb[j] = b_fb[j-1];
    end else begin : g_lo_tie
      assign lo_fb[j] = '0;
    end
    // hi side: net j is the first input of cell j
    if (j < N_CELLS) begin : g_hi
      assign hi_fb[j] = a_fb[j];
    end else begin : g_hi_tie
      assign hi_fb[j] = '0;
    end

    nand_emu_net u_net (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_i      (mode),
      .force_en_i  (in_force_en_i[j]),
      .force_val_i (in_force_val_i[j]),
      .lo_fb_i     (lo_fb[j]),
      .hi_fb_i     (hi_fb[j]),
      .q_o         (net_q[j])
    );
  end

  assign net_o = net_q;

endmodule

// File: tb/sim_nand_emu_chain.sv
module sim_nand_emu_chain;

  localparam int N  = 4;
  localparam int NI = N + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode = 1'b0;
  logic [NI-1:0] ife = '0, ifv = '0;
  logic [N-1:0]  ofe = '0, ofv = '0, sa0 = '0, sa1 = '0, pre = '0, clr = '0;
  logic [NI-1:0] net_o;
  logic [N-1:0]  out_o, stable_o;

  int checks = 0;
  int fails  = 0;

  logic [NI-1:0] m_in;
  logic [N-1:0]  m_out;

  always #5 clk = ~clk;

  nand_emu_chain #(.N_CELLS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .in_force_en_i(ife), .in_force_val_i(ifv),
    .out_force_en_i(ofe), .out_force_val_i(ofv),
    .sa0_i(sa0), .sa1_i(sa1), .preset_i(pre), .clear_i(clr),
    .net_o(net_o), .out_o(out_o), .stable_o(stable_o)
  );

  task automatic chk(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b exp %0b", tag, what, got, exp);
    end
  endtask

  // Reference next value of output k, with the rule that selected it
  function automatic logic ref_out(int k, output string tag);
    if (sa0[k])       begin tag = "R6"; return 1'b0; end
    if (sa1[k])       begin tag = "R7"; return 1'b1; end
    if (pre[k])       begin tag = "R8"; return 1'b1; end
    if (clr[k])       begin tag = "R8"; return 1'b0; end
    if (ofe[k])       begin tag = "R9"; return ofv[k]; end
    if (mode == 1'b0) begin tag = "R2"; return ~(m_in[k] & m_in[k+1]); end
    tag = "R3";
    return m_out[k];
  endfunction

  // Reference next value of net j
  function automatic logic ref_net(int j, output string tag);
    logic y, oth;
    if (ife[j]) begin tag = "R9"; return ifv[j]; end
    if (mode == 1'b0) begin tag = "R2"; return m_in[j]; end
    if (j > 0) begin
      y = m_out[j-1]; oth = m_in[j-1];
      if (!y || oth) begin tag = y ? "R4" : "R3"; return ~y; end
    end
    if (j < N) begin
      y = m_out[j]; oth = m_in[j+1];
      if (!y || oth) begin
        tag = (j > 0) ? "R5" : (y ? "R4" : "R3");
        return ~y;
      end
    end
    tag = "R4";
    return m_in[j];
  endfunction

  // Called at a negedge with inputs already applied
  task automatic step();
    logic [NI-1:0] n_in;
    logic [N-1:0]  n_out;
    string t_in [NI];
    string t_out [N];
    string t;
    for (int k = 0; k < N; k++) begin n_out[k] = ref_out(k, t); t_out[k] = t; end
    for (int j = 0; j < NI; j++) begin n_in[j] = ref_net(j, t); t_in[j] = t; end
    #1;
    for (int k = 0; k < N; k++) chk("R10", $sformatf("stable[%0d]", k), stable_o[k], n_out[k] == m_out[k]);
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < N; k++)  chk(t_out[k], $sformatf("out[%0d]", k), out_o[k], n_out[k]);
    for (int j = 0; j < NI; j++) chk(t_in[j],  $sformatf("net[%0d]", j), net_o[j], n_in[j]);
    m_in  = n_in;
    m_out = n_out;
  endtask

  task automatic idle();
    ife = '0; ifv = '0; ofe = '0; ofv = '0;
    sa0 = '0; sa1 = '0; pre = '0; clr = '0;
  endtask

  task automatic check_zero(string what);
    for (int j = 0; j < NI; j++) chk("R1", $sformatf("%s net[%0d]", what, j), net_o[j], 1'b0);
    for (int k = 0; k < N; k++)  chk("R1", $sformatf("%s out[%0d]", what, k), out_o[k], 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_zero("reset");
    rst_ni = 1'b1;
    m_in = '0; m_out = '0;

    // R3: force all outputs to 0, then justify backward -> all nets 1
    idle(); ofe = '1; ofv = '0; step();
    idle(); mode = 1'b1; step();
    // R2: forward evaluation of all-ones nets -> outputs 0
    idle(); mode = 1'b0; step();
    // R6 over R7: both faults high
    idle(); sa0 = '1; sa1 = '1; pre = '1; step();
    // R7 over preset/clear/force
    idle(); sa1 = '1; clr = '1; ofe = '1; ofv = '0; step();
    // R4: outputs 1 with all nets 1 -> nets go 0 backward
    idle(); mode = 1'b1; step();
    // R4 hold: outputs 1 and nets 0 -> nothing determined
    idle(); mode = 1'b1; step();
    // R5: cell0 undetermined (out 1, net0 0), cell1 out 0 drives net1
    idle(); ofe = 4'b0010; ofv = 4'b0001; ife = '1; ifv = '0; step();
    idle(); mode = 1'b1; step();
    // R8: preset beats clear, clear beats force
    idle(); pre = 4'b0101; clr = 4'b1111; ofe = '1; ofv = '1; step();

    for (int i = 0; i < 2500; i++) begin
      mode = $urandom_range(0, 1);
      for (int j = 0; j < NI; j++) begin
        ife[j] = ($urandom_range(0, 5) == 0);
        ifv[j] = $urandom_range(0, 1);
      end
      for (int k = 0; k < N; k++) begin
        ofe[k] = ($urandom_range(0, 5) == 0);
        ofv[k] = $urandom_range(0, 1);
        sa0[k] = ($urandom_range(0, 15) == 0);
        sa1[k] = ($urandom_range(0, 15) == 0);
        pre[k] = ($urandom_range(0, 15) == 0);
        clr[k] = ($urandom_range(0, 15) == 0);
      end
      step();
    end

    // R1: asynchronous reset mid-run, after forcing ones
    idle(); mode = 1'b0; ife = '1; ifv = '1; pre = '1; step();
    #2 rst_ni = 1'b0;
    #1 check_zero("async");
    @(negedge clk);
    check_zero("held");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule